// File: doc/BRIEF.md
# Fixed-Ratio Shift-Add Scaler

This unit converts an unsigned 32-bit position count `x` into a scaled integer `i = floor(x * 10000 / 16384)`. It has no multiplier. The ratio reduces to 625/1024, which is 0.1001110001 in binary. The unit evaluates the product with a fixed schedule of additions and logical right shifts taken from that binary expansion, and it spends one clock on each scheduled step.

The recurrence first loads `x` logically shifted right by four places. It then runs four steps in a fixed order. Each step adds the original `x` to the accumulator and only afterwards shifts the sum right, by 1, 1, 3 and then 1 place. The accumulator keeps ten fraction bits below the integer part, so no bit is lost in any shift. The returned integer part is therefore exact for every input value. The unit never forms `x * 10000` as a full product, so inputs above roughly 429 thousand cannot wrap a 32-bit intermediate.

A caller raises `start` for one cycle with the operand on `x_in`. It then waits for the one-cycle `done` pulse. `result` keeps its value until the next operation completes.

Top module: `shadd_scaler`

## Requirements
- R1: For every 32-bit unsigned `x_in`, the completed `result` equals floor(x_in * 10000 / 16384), which is the same as (x_in * 625) >> 10 computed without truncation.
- R2: An operand of 0 produces a result of 0.
- R3: An operand of 0xFFFFFFFF produces a result of 0x9C3FFFFF (2621439999).
- R4: When `start` is sampled high while idle, `busy` is high for the next four cycles and `done` stays low during them. On the fourth rising edge after the accepting edge, `done` goes high for exactly one cycle, `busy` falls and `result` presents the new value.
- R5: `start` is ignored while `busy` is high. The operand is not re-latched, no extra completion occurs, and the result belongs to the operand accepted first.
- R6: During and directly after synchronous active-low reset, `busy`, `done` and `result` are all zero.
- R7: Operands whose product with 10000 does not fit in 32 bits, such as 429497 and 0x80000000, are scaled correctly. For 0x80000000 the result is 0x4E200000.
- R8: `result` holds its value in every cycle in which `done` is low. A `start` sampled in the cycle where `done` is high is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to scale `x_in`; accepted only while idle |
| x_in | input | 32 | Unsigned operand, sampled on the accepting edge |
| result | output | 32 | Integer part of the scaled operand |
| busy | output | 1 | High while the recurrence steps are running |
| done | output | 1 | One-cycle pulse marking a fresh `result` |

## Verification
Two situations are hard to reach from the ports. The first is an input whose exact result depends on every low fraction bit surviving all four shifts. The second is a restart request that arrives in the middle of the step sequence. The bench covers the first with a long run of pseudo-random operands plus the all-ones and power-of-two edges, each compared against a 64-bit reference. It covers the second by holding `start` high with a different operand through all the busy cycles. It drops `start` just before the completion edge, then confirms that the first operand's result appears and that no second completion follows.

// File: rtl/shadd_pkg.sv
// Package: shared constants and the step schedule of the scaler.
// Assumes the ratio 625/1024 = 0.1001110001b is fixed at design time;
// the schedule below is the add-then-shift expansion of that constant.
package shadd_pkg;

    // Logical right shift applied to x when the accumulator is loaded.
    localparam int unsigned PRE_SHIFT = 4;

    // Number of add-then-shift steps after the load.
    localparam int unsigned N_STEPS = 4;

    localparam int unsigned STEP_IDX_W = $clog2(N_STEPS);

    // Shift amount applied after the addition in step idx.
    function automatic int unsigned step_shift(input int unsigned idx);
        case (idx)
            0:       return 1;
            1:       return 1;
            2:       return 3;
            default: return 1;
        endcase
    endfunction

    // Total right shift over the whole recurrence (fraction bits needed).
    function automatic int unsigned total_shift();
        int unsigned s;
        s = PRE_SHIFT;
        for (int unsigned k = 0; k < N_STEPS; k++) begin
            s = s + step_shift(k);
        end
        return s;
    endfunction

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } scaler_state_e;

endpackage

// File: rtl/shadd_ctrl.sv
// Module: sequencer of the scaler.
// Accepts a start while idle, walks the step index through N_STEPS clocks
// and pulses done on the clock that retires the last step.
// Assumes start is a level sampled on rising edges; it has no effect while running.
module shadd_ctrl
    import shadd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  load,
    output logic                  step_en,
    output logic                  last_step,
    output logic [STEP_IDX_W-1:0] step_idx,
    output logic                  busy,
    output logic                  done
);

    scaler_state_e         state_q;
    logic [STEP_IDX_W-1:0] idx_q;
    logic                  done_q;

    // Decode the strobes that drive the datapath.
    always_comb begin
        load      = (state_q == ST_IDLE) && start;
        step_en   = (state_q == ST_RUN);
        last_step = (state_q == ST_RUN) && (idx_q == STEP_IDX_W'(N_STEPS - 1));
    end

    // Advance the state, the step index and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        idx_q   <= '0;
                    end
                end
                default: begin
                    if (idx_q == STEP_IDX_W'(N_STEPS - 1)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign step_idx = idx_q;
    assign busy     = (state_q == ST_RUN);
    assign done     = done_q;

    // R4: done is a single-cycle pulse.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: the busy window always closes with a completion.
    a_r4_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

// File: rtl/shadd_datapath.sv
// Module: accumulator datapath of the scaler.
// Holds the operand and a fixed-point accumulator with FRAC fraction bits.
// On load, the accumulator takes x >> PRE_SHIFT. Each step adds x and then
// shifts right logically by the scheduled amount. Assumes FRAC is at least
// the total shift, so every shift is exact and the integer part is floor().
module shadd_datapath
    import shadd_pkg::*;
#(
    parameter int unsigned XW   = 32,
    parameter int unsigned FRAC = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step_en,
    input  logic                  last_step,
    input  logic [STEP_IDX_W-1:0] step_idx,
    input  logic [XW-1:0]         x_in,
    output logic [XW-1:0]         result
);

    // Two guard bits: the accumulator plus x stays below 3 * 2^(XW+FRAC).
    localparam int unsigned ACC_W = XW + FRAC + 2;

    logic [XW-1:0]    x_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] x_fix;
    logic [ACC_W-1:0] load_val;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] cand [N_STEPS];
    logic [ACC_W-1:0] acc_next;
    logic [XW-1:0]    result_q;

    // Place the operands on the fixed-point grid and form the step sum.
    always_comb begin
        x_fix    = ACC_W'({x_q, {FRAC{1'b0}}});
        load_val = ACC_W'({x_in, {FRAC{1'b0}}}) >> PRE_SHIFT;
        sum      = acc_q + x_fix;
    end

    // One logical shifter per scheduled step; the shift follows the add.
    for (genvar k = 0; k < N_STEPS; k++) begin : g_step
        assign cand[k] = sum >> step_shift(k);
    end

    // Pick the shifter output for the current step.
    assign acc_next = cand[step_idx];

    // Load the operand, run the recurrence and capture the integer part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q      <= '0;
            acc_q    <= '0;
            result_q <= '0;
        end else if (load) begin
            x_q   <= x_in;
            acc_q <= load_val;
        end else if (step_en) begin
            acc_q <= acc_next;
            if (last_step) begin
                result_q <= acc_next[FRAC +: XW];
            end
        end
    end

    assign result = result_q;

    // R5: the latched operand does not move while the steps run.
    a_r5_operand_held: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (!step_en || $stable(x_q)));

endmodule

// File: rtl/shadd_scaler.sv
// Module: top of the fixed-ratio shift-add scaler.
// Computes floor(x * 10000 / 16384) for an unsigned operand through the
// schedule in shadd_pkg, one step per clock, with start/busy/done handshake.
// Assumes the caller holds off new work until done, since start is ignored while busy.
module shadd_scaler
    import shadd_pkg::*;
#(
    parameter int unsigned XW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [XW-1:0] x_in,
    output logic [XW-1:0] result,
    output logic          busy,
    output logic          done
);

    localparam int unsigned FRAC = total_shift();

    logic                  load;
    logic                  step_en;
    logic                  last_step;
    logic [STEP_IDX_W-1:0] step_idx;

    shadd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (load),
        .step_en   (step_en),
        .last_step (last_step),
        .step_idx  (step_idx),
        .busy      (busy),
        .done      (done)
    );

    shadd_datapath #(
        .XW   (XW),
        .FRAC (FRAC)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step_en   (step_en),
        .last_step (last_step),
        .step_idx  (step_idx),
        .x_in      (x_in),
        .result    (result)
    );

    // R8: the result changes only on a completion.
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R4: a completion always follows a busy cycle.
    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

endmodule

// File: tb/shadd_scaler_test.sv
// Directed bench for shadd_scaler: one task per scenario, each checking itself.
module shadd_scaler_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] x_in = '0;
    logic [31:0] result;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    shadd_scaler uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .x_in   (x_in),
        .result (result),
        .busy   (busy),
        .done   (done)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL R4 watchdog actual=%0d cycles expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] ref_scale(input logic [31:0] x);
        logic [63:0] p;
        p = ({32'd0, x} * 64'd10000) >> 14;
        return p[31:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // Runs one operation; caller is at a negedge. Returns at the negedge with done high.
    task automatic run_op(input logic [31:0] x, input string req);
        x_in  = x;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 4; c++) begin
            chk(busy == 1'b1 && done == 1'b0, "R4", "busy window",
                {30'd0, busy, done}, 32'd2);
            if (c < 3) @(negedge clk);
        end
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R4", "completion edge",
            {30'd0, busy, done}, 32'd1);
        chk(result == ref_scale(x), req, "scaled value", result, ref_scale(x));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && result == 32'd0, "R6", "reset state",
            {result[29:0], busy, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && result == 32'd0, "R6", "after reset",
            {result[29:0], busy, done}, 32'd0);
    endtask

    task automatic t_edges();
        @(negedge clk);
        run_op(32'd0, "R2");
        chk(result == 32'd0, "R2", "zero operand", result, 32'd0);
        @(negedge clk);
        run_op(32'hFFFF_FFFF, "R3");
        chk(result == 32'h9C3F_FFFF, "R3", "all-ones operand", result, 32'h9C3F_FFFF);
        @(negedge clk);
        run_op(32'd1024, "R1");
        chk(result == 32'd625, "R1", "exact multiple", result, 32'd625);
        @(negedge clk);
        run_op(32'd1023, "R1");
        chk(result == 32'd624, "R1", "floor below multiple", result, 32'd624);
    endtask

    task automatic t_wide();
        @(negedge clk);
        run_op(32'd429497, "R7");
        @(negedge clk);
        run_op(32'h8000_0000, "R7");
        chk(result == 32'h4E20_0000, "R7", "half range", result, 32'h4E20_0000);
        @(negedge clk);
        run_op(32'hFFFF_FC00, "R7");
    endtask

    task automatic t_random();
        logic [31:0] s;
        s = 32'h1234_5678;
        for (int n = 0; n < 300; n++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            @(negedge clk);
            run_op(s, "R1");
        end
    endtask

    task automatic t_busy_start();
        int extra;
        @(negedge clk);
        x_in  = 32'h0012_3456;
        start = 1'b1;
        @(negedge clk);
        x_in = 32'hFEDC_BA98;
        repeat (2) @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0, "R5", "still busy under start",
            {30'd0, busy, done}, 32'd2);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b1, "R5", "single completion", {31'd0, done}, 32'd1);
        chk(result == ref_scale(32'h0012_3456), "R5", "first operand kept",
            result, ref_scale(32'h0012_3456));
        extra = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (done || busy) extra = extra + 1;
        end
        chk(extra == 0, "R5", "no second run", extra, 32'd0);
    endtask

    task automatic t_hold_and_chain();
        logic [31:0] held;
        @(negedge clk);
        run_op(32'd77777, "R1");
        held = result;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            x_in = 32'hA5A5_0000 + c;
            chk(result == held && done == 1'b0, "R8", "result held", result, held);
        end
        @(negedge clk);
        run_op(32'd5000, "R8");
        run_op(32'd123456789, "R8");
        run_op(32'hDEAD_BEEF, "R8");
    endtask

    initial begin
        t_reset();
        t_edges();
        t_wide();
        t_busy_start();
        t_hold_and_chain();
        t_random();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule